// File: doc/BRIEF.md
# Eager One-Hot Token Multiplexer

This block joins N candidate values into one result stream. Each candidate arrives on its own data channel, and a matching predicate channel carries one bit that says whether that candidate's control path was taken. The selector is not an encoded index. There is one predicate bit per input, and the predicates of a correct evaluation are mutually exclusive. The data path is a plain AND-OR of the inputs gated by the chosen line, so no select encoder or decoder sits in front of it.

The block is eager. It registers a result on the first clock edge where some input has both a valid true predicate and valid data. It does not wait for the other predicates or for data on paths that were not taken. Once the consumer takes the result, the block retires the whole evaluation. It acknowledges the chosen data, every predicate, and every speculative data value that was not chosen, each as its token shows up. Only then does it open for the next evaluation. This lets every wire be reused on the next loop iteration without mixing values from two evaluations.

Every channel, input and output, follows one transfer rule. The producer raises valid and holds valid and data steady. A transfer happens on the rising clock edge where valid and acknowledge are both high. The acknowledge plays the role of ready and gives back-pressure. The block never withdraws its output before the transfer. A producer whose value has not been acknowledged must keep it presented.

Top module: `eager_pick`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_valid, out_multi, every in_ack and every sel_ack are 0.
- R2: While idle, if some input i has in_valid[i], sel_valid[i] and sel_bit[i] all high at a rising edge, out_valid is high after that edge and out_data equals input i's data. This holds whatever the state of the other inputs. Input i occupies in_data bits [i*DW +: DW].
- R3: While idle, if no input has valid data together with a valid true predicate, out_valid stays low after the edge.
- R4: If several inputs qualify at the firing edge, the lowest index wins. out_multi is high with the result exactly when more than one predicate was valid and true at that edge.
- R5: While out_valid is high and out_ack is low, out_valid stays high and out_data and out_multi do not change. The edge where out_ack is high clears out_valid.
- R6: No in_ack or sel_ack is raised while the result has not yet been taken.
- R7: After the result is taken, each data channel and each predicate channel is acknowledged exactly once for this evaluation. The acknowledge comes in the first cycle its valid is high, and a channel whose token arrives late is acknowledged when it arrives.
- R8: Until every channel of the current evaluation has been acknowledged, new tokens are neither acknowledged nor able to produce a result. The next result can appear no earlier than the second edge after the last acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Data token present, one bit per input |
| in_data | input | N_IN*DW | Packed candidate values, input i at [i*DW +: DW] |
| in_ack | output | N_IN | Data token consumed, one bit per input |
| sel_valid | input | N_IN | Predicate token present, one bit per input |
| sel_bit | input | N_IN | Predicate value, 1 means this input's path was taken |
| sel_ack | output | N_IN | Predicate token consumed, one bit per input |
| out_valid | output | 1 | Result present |
| out_data | output | DW | Selected value |
| out_ack | input | 1 | Consumer takes the result |
| out_multi | output | 1 | More than one predicate was true when the result fired |

## Verification
The assertions assume the producers obey the transfer rule: valid and data are held until acknowledged, and no token is withdrawn early. They also assume the consumer holds out_ack for one cycle per result. The bench drives all inputs at falling edges. It drops a token only on the edge after its acknowledge was seen, and it pulses out_ack for a single cycle. The sweep also feeds many-hot predicates to exercise the error path. The assertions do not rely on one-hot predicates, because that is checked by the flag rather than assumed.

// File: rtl/eap_pkg.sv
package eap_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_OFFER = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;
endpackage

// File: rtl/eap_first_hot.sv
module eap_first_hot #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign gnt[g]      = req[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req[g];
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  assert_grant_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/eap_drain_track.sv
module eap_drain_track #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [N-1:0] tok,
  output logic [N-1:0] ack,
  output logic         complete
);
  logic [N-1:0] done_q;
  logic [N-1:0] done_nx;

  assign ack      = {N{en}} & tok & ~done_q;
  assign done_nx  = done_q | ack;
  assign complete = &done_nx;

  always_ff @(posedge clk) begin
    if (!rst_n)   done_q <= '0;
    else if (clr) done_q <= '0;
    else          done_q <= done_nx;
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_single_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack[g] |=> !ack[g]);
    assert_ack_needs_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack[g] |-> tok[g]);
  end
endmodule

// File: rtl/eager_pick.sv
module eager_pick #(
  parameter int N_IN = 4,
  parameter int DW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_valid,
  input  logic [N_IN*DW-1:0] in_data,
  output logic [N_IN-1:0]   in_ack,
  input  logic [N_IN-1:0]   sel_valid,
  input  logic [N_IN-1:0]   sel_bit,
  output logic [N_IN-1:0]   sel_ack,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  input  logic              out_ack,
  output logic              out_multi
);
  import eap_pkg::*;

  phase_e         ph;
  logic [N_IN-1:0] live_true;
  logic [N_IN-1:0] cand;
  logic [N_IN-1:0] gnt;
  logic [DW-1:0]   mux_y;
  logic            multi_now;
  logic            draining;
  logic            d_cmp, p_cmp, finish;

  assign live_true = sel_valid & sel_bit;
  assign cand      = live_true & in_valid;
  assign draining  = (ph == PH_DRAIN);
  assign finish    = draining & d_cmp & p_cmp;

  eap_first_hot #(.N(N_IN)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(cand), .gnt(gnt)
  );

  always_comb begin
    logic any_seen;
    mux_y     = '0;
    multi_now = 1'b0;
    any_seen  = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      mux_y = mux_y | (in_data[i*DW +: DW] & {DW{gnt[i]}});
      if (live_true[i]) begin
        if (any_seen) multi_now = 1'b1;
        any_seen = 1'b1;
      end
    end
  end

  eap_drain_track #(.N(N_IN)) u_dtrk (
    .clk(clk), .rst_n(rst_n), .en(draining), .clr(finish),
    .tok(in_valid), .ack(in_ack), .complete(d_cmp)
  );

  eap_drain_track #(.N(N_IN)) u_ptrk (
    .clk(clk), .rst_n(rst_n), .en(draining), .clr(finish),
    .tok(sel_valid), .ack(sel_ack), .complete(p_cmp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_WAIT;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_multi <= 1'b0;
    end else begin
      case (ph)
        PH_WAIT: if (|cand) begin
          ph        <= PH_OFFER;
          out_valid <= 1'b1;
          out_data  <= mux_y;
          out_multi <= multi_now;
        end
        PH_OFFER: if (out_ack) begin
          ph        <= PH_DRAIN;
          out_valid <= 1'b0;
          out_multi <= 1'b0;
        end
        PH_DRAIN: if (finish) ph <= PH_WAIT;
        default: ph <= PH_WAIT;
      endcase
    end
  end

  assert_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT && (|cand)) |=> out_valid);
  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT && cand == '0) |=> !out_valid);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_data) && $stable(out_multi)));
  assert_no_early_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ack == '0 && sel_ack == '0));
  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DRAIN) |-> !out_valid);
endmodule

// File: tb/sim_eager_pick.sv
module sim_eager_pick;
  localparam int N  = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    dv = '0, pv = '0, pb = '0;
  logic [DW-1:0]   dd [N];
  logic [N*DW-1:0] flat;
  logic [N-1:0]    in_ack, sel_ack;
  logic            y_valid, y_err;
  logic [DW-1:0]   y_data;
  logic            y_ack = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign flat[g*DW +: DW] = dd[g];
  end

  eager_pick #(.N_IN(N), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dv), .in_data(flat), .in_ack(in_ack),
    .sel_valid(pv), .sel_bit(pb), .sel_ack(sel_ack),
    .out_valid(y_valid), .out_data(y_data), .out_ack(y_ack), .out_multi(y_err)
  );

  int n_chk = 0, n_fail = 0;
  int dcnt [N], pcnt [N], snd [N], snp [N];
  logic [N-1:0] d_hit = '0, p_hit = '0;

  initial for (int i = 0; i < N; i++) begin
    dcnt[i] = 0; pcnt[i] = 0; dd[i] = '0;
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      d_hit[i] = dv[i] & in_ack[i];
      p_hit[i] = pv[i] & sel_ack[i];
      if (d_hit[i]) dcnt[i] = dcnt[i] + 1;
      if (p_hit[i]) pcnt[i] = pcnt[i] + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < N; i++) begin snd[i] = dcnt[i]; snp[i] = pcnt[i]; end
  endtask

  task automatic drop_acked();
    dv = dv & ~d_hit;
    pv = pv & ~p_hit;
  endtask

  // retire an evaluation: drop acked tokens, offer late data, count acks (R7)
  task automatic drain(input logic [N-1:0] late);
    for (int c = 0; c < 40; c++) begin
      drop_acked();
      if (c == 2) dv = dv | late;
      if (c > 2 && dv == '0 && pv == '0) break;
      @(negedge clk);
    end
    for (int i = 0; i < N; i++) begin
      chk(dcnt[i] - snd[i] == 1, "R7 data ack count", dcnt[i] - snd[i], 1);
      chk(pcnt[i] - snp[i] == 1, "R7 pred ack count", pcnt[i] - snp[i], 1);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!y_valid && !y_err, "R1 outputs in reset", {y_valid, y_err}, 0);
    chk(in_ack == '0 && sel_ack == '0, "R1 acks in reset", {in_ack, sel_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!y_valid && in_ack == '0 && sel_ack == '0, "R1 after reset", y_valid, 0);

    for (int pm = 1; pm < 16; pm++) begin
      for (int dm = 0; dm < 16; dm++) begin
        logic [N-1:0] cand, late;
        int w, snd_sum, snp_sum;
        @(negedge clk);
        snap();
        for (int i = 0; i < N; i++) dd[i] = 16'(pm * 4096 + dm * 256 + i * 17 + 3);
        pv = '1; pb = 4'(pm); dv = 4'(dm);
        cand = 4'(pm & dm);
        @(negedge clk);
        if (cand == '0) begin
          chk(!y_valid, "R3 no candidate", y_valid, 0);
          dv = '1;
          late = '0;
          w = lowest(4'(pm));
          @(negedge clk);
        end else begin
          late = ~(4'(dm));
          w = lowest(cand);
        end
        chk(y_valid, "R2 eager fire", y_valid, 1);
        chk(y_data == dd[w], "R2/R4 selected data", y_data, dd[w]);
        chk(y_err == ($countones(4'(pm)) > 1), "R4 multi flag", y_err, $countones(4'(pm)) > 1);
        snd_sum = 0; snp_sum = 0;
        for (int i = 0; i < N; i++) begin
          snd_sum += dcnt[i] - snd[i]; snp_sum += pcnt[i] - snp[i];
        end
        @(negedge clk);
        chk(y_valid && y_data == dd[w], "R5 hold", y_data, dd[w]);
        chk(in_ack == '0 && sel_ack == '0 && snd_sum == 0 && snp_sum == 0,
            "R6 no early ack", {in_ack, sel_ack}, 0);
        y_ack = 1'b1;
        @(negedge clk);
        y_ack = 1'b0;
        chk(!y_valid, "R5 release", y_valid, 0);
        drain(late);
      end
    end

    // R8: new tokens wait until the old evaluation is fully retired
    @(negedge clk);
    snap();
    for (int i = 0; i < N; i++) dd[i] = 16'(16'h1000 + i);
    pv = '1; pb = 4'b0001; dv = 4'b0001;
    @(negedge clk);
    chk(y_valid && y_data == 16'h1000, "R2 directed fire", y_data, 16'h1000);
    y_ack = 1'b1;
    @(negedge clk);
    y_ack = 1'b0;
    for (int c = 0; c < 4; c++) begin drop_acked(); @(negedge clk); end
    drop_acked();
    begin
      int d0;
      d0 = dcnt[0];
      dv[0] = 1'b1; pv[0] = 1'b1; pb = 4'b0001; dd[0] = 16'hBEEF;
      repeat (3) @(negedge clk);
      chk(!y_valid, "R8 no result while draining", y_valid, 0);
      chk(dcnt[0] == d0 && in_ack[0] == 1'b0, "R8 new token not acked", dcnt[0] - d0, 0);
      dv[3:1] = 3'b111;
      @(negedge clk);
      dv[3:1] = dv[3:1] & ~d_hit[3:1];
      chk(!y_valid, "R8 retire edge", y_valid, 0);
      @(negedge clk);
      chk(y_valid && y_data == 16'hBEEF, "R8 next evaluation fires", y_data, 16'hBEEF);
    end
    y_ack = 1'b1;
    @(negedge clk);
    y_ack = 1'b0;
    snap();
    pv[3:1] = 3'b111; pb = 4'b0001;
    drain(4'b1110);

    finish_run();
  end
endmodule